// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block drives the address of a four-beat burst into a synchronous memory. A load strobe captures a full starting address and begins a new burst. After that, every clock edge at which the advance strobe is high moves the burst to its next beat. Only the low two address bits change from beat to beat. The upper bits stay at the value loaded until the next load.

The beat order is fixed while reset is held, by sampling a mode pin. In linear order, beat n sits at (start + n) mod 4, so the sequence wraps around inside its four-word block. In interleaved order, beat n sits at start XOR n, which is the pairwise-swapping order that some cache-line fill protocols expect.

All inputs are taken at the rising clock edge. The address output comes from registered state, so every result appears in the cycle after the edge that caused it.

Top module: `burst_addr_gen`

## Requirements
- R1: At the first clock edge with reset (rst_n low), the address output clears to zero. The beat index also clears to zero.
- R2: When load_i is high at a clock edge, addr_o equals the start_addr_i sampled at that edge from the following cycle onward.
- R3: With linear order selected (mode_i = 0 during reset), each advance leaves the low two bits of addr_o at (start + n) mod 4, where n counts advances since the load.
- R4: With interleaved order selected (mode_i = 1 during reset), each advance leaves the low two bits of addr_o at start XOR n.
- R5: An edge with neither load_i nor adv_i high leaves addr_o unchanged.
- R6: load_i takes priority over adv_i. A load in the same cycle as an advance, or in the middle of a burst, restarts from the new start address at beat 0.
- R7: Advances never change the upper address bits (all bits above the low two), including advances past the fourth beat.
- R8: mode_i is sampled only while reset is held. Changing mode_i after reset does not alter the order of later bursts.
- R9: Four advances after a load return addr_o to the loaded start address, and further advances repeat the same four-beat pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; mode_i is sampled while it is low |
| load_i | input | 1 | Start a new burst from start_addr_i |
| start_addr_i | input | ADDR_W (20) | Full starting address of the burst |
| adv_i | input | 1 | Step to the next beat of the current burst |
| mode_i | input | 1 | Burst order, sampled in reset: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W (20) | Current burst address |

## Verification
Every result of this block is due exactly one clock after the edge that caused it:
- a load shows its start address one cycle later;
- an advance shows the next beat one cycle later;
- reset shows zero one cycle later.

The bench drives inputs on the falling edge. A behavioural model (integers for the start, the beat count and the order) is updated on each rising edge from the same inputs the design sampled. The model is compared with addr_o on the next falling edge, so each comparison lands half a period after the register that produced the result. The directed checks at the wrap point, at a load colliding with an advance, and after a mode change are sampled at that same falling edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst ordering, captured while reset is held.
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/burst_mode_latch.sv
module burst_mode_latch
  import burst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mode_i,
  output order_e order_o
);

  order_e order_q;

  // The mode pin is followed only while reset is held and frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) order_q <= order_e'(mode_i);
  end

  assign order_o = order_q;

  // R8: once out of reset the captured order never moves
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(order_q));

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              wrap_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};
  localparam logic [BEAT_W-1:0] ONE_BEAT  = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_q;
  logic              step_evt;

  assign step_evt = adv_i && !load_i;
  assign wrap_o   = step_evt && (beat_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_i)   beat_q <= '0;
    else if (step_evt) beat_q <= beat_q + ONE_BEAT;
  end

  assign beat_o = beat_q;

  // R9: a step from the last beat lands back on beat zero
  assert_beat_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (beat_o == '0));

  // R5: no strobe, no movement
  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(beat_o));

  // R6: any load restarts at beat zero, whatever the advance strobe does
  assert_load_beat_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);

  // Linear order: wrap-around sum inside the block.
  function automatic logic [BEAT_W-1:0] linear_offset(
    input logic [BEAT_W-1:0] s,
    input logic [BEAT_W-1:0] n
  );
    return s + n;
  endfunction

  // Interleaved order: bitwise toggle of the start by the beat index.
  function automatic logic [BEAT_W-1:0] interleave_offset(
    input logic [BEAT_W-1:0] s,
    input logic [BEAT_W-1:0] n
  );
    return s ^ n;
  endfunction

  always_comb begin
    if (order_i == ORDER_INTERLEAVE) low_o = interleave_offset(start_low_i, beat_i);
    else                             low_o = linear_offset(start_low_i, beat_i);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int            HI_W     = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] ONE_BEAT = BEAT_W'(1);

  order_e            order;
  logic [BEAT_W-1:0] beat;
  logic              wrap_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] low;

  // Named events for the checks below.
  assign step_evt = adv_i && !load_i;

  burst_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .order_o (order)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .adv_i  (adv_i),
    .beat_o (beat),
    .wrap_o (wrap_evt)
  );

  // Start address of the current burst; only a load rewrites it.
  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (load_i) base_q <= start_addr_i;
  end

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_low_i (base_q[BEAT_W-1:0]),
    .beat_i      (beat),
    .order_i     (order),
    .low_o       (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};

  // R1: the cycle after reset shows address zero
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (addr_o == '0));

  // R2: a load shows its start address one cycle later
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(start_addr_i)));

  // R6: load wins over a simultaneous advance
  assert_load_over_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (addr_o == $past(start_addr_i)));

  // R3: linear steps add one to the low bits
  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order == ORDER_LINEAR) |=>
      (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + ONE_BEAT));

  // R4: interleaved steps toggle the bits that change in the beat index
  assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order == ORDER_INTERLEAVE) |=>
      ((addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) ==
       ($past(beat) ^ ($past(beat) + ONE_BEAT))));

  // R5: no strobe leaves the address alone
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(addr_o));

  // R7: upper bits only move on a load
  assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  // R9: a wrap returns the low bits to those of the loaded start
  assert_wrap_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (addr_o == base_q));

  initial begin
    assert_width_R7: assert (HI_W > 0);
  end

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic              adv_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_ok = 0;
  string cur_req = "R1";

  // Behavioural reference state.
  int m_start = 0;
  int m_beats = 0;
  int m_inter = 0;

  always #10 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .adv_i        (adv_i),
    .mode_i       (mode_i),
    .addr_o       (addr_o)
  );

  function automatic int model_addr();
    int lo;
    int s_lo;
    s_lo = m_start % 4;
    if (m_inter != 0) lo = s_lo ^ (m_beats % 4);
    else              lo = (s_lo + m_beats) % 4;
    return (m_start / 4) * 4 + lo;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0;
      m_beats = 0;
      m_inter = mode_i ? 1 : 0;
    end else if (load_i) begin
      m_start = int'(start_addr_i);
      m_beats = 0;
    end else if (adv_i) begin
      m_beats = m_beats + 1;
    end
    model_ok = 1;
  end

  task automatic check(input string req, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: addr_o=%05h expected=%05h", req, got, want);
    end
  endtask

  // Per-cycle comparison against the model, half a period after each edge.
  always @(negedge clk) begin
    if (model_ok && !done) check(cur_req, int'(addr_o), model_addr());
  end

  task automatic tick(input bit ld, input int sa, input bit adv);
    @(negedge clk);
    load_i = ld;
    start_addr_i = ADDR_W'(sa);
    adv_i = adv;
  endtask

  task automatic do_reset(input bit md);
    @(negedge clk);
    rst_n = 1'b0;
    mode_i = md;
    load_i = 1'b0;
    adv_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: addr_o=%05h expected=done", addr_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset clears the output
    cur_req = "R1";
    do_reset(1'b0);
    check("R1", int'(addr_o), 0);

    // R2 / R3: linear burst from a start with low bits 01
    cur_req = "R2";
    tick(1, 'h12345, 0);
    tick(0, 0, 0);
    check("R2", int'(addr_o), 'h12345);
    cur_req = "R3";
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R3", int'(addr_o), 'h12346);
    tick(0, 0, 1);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R3", int'(addr_o), 'h12344);

    // R9: fourth advance lands on the start again, then the pattern repeats
    cur_req = "R9";
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R9", int'(addr_o), 'h12345);
    // R7: advancing past the fourth beat keeps the upper bits
    cur_req = "R7";
    tick(0, 0, 1);
    tick(0, 0, 1);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R7", int'(addr_o) >> 2, 'h12345 >> 2);

    // R5: no strobe for several cycles
    cur_req = "R5";
    for (int i = 0; i < 4; i++) tick(0, 'hFFFFF, 0);
    check("R5", int'(addr_o), 'h12344);

    // R6: load with advance in the same cycle, mid-burst
    cur_req = "R6";
    tick(0, 0, 1);
    tick(1, 'hABCDE, 1);
    tick(0, 0, 0);
    check("R6", int'(addr_o), 'hABCDE);

    // R8: mode pin changed after reset does not switch the order
    cur_req = "R8";
    mode_i = 1'b1;
    tick(1, 'h00031, 0);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R8", int'(addr_o), 'h00032);

    // R4: interleaved order selected in reset
    cur_req = "R4";
    do_reset(1'b1);
    check("R1", int'(addr_o), 0);
    tick(1, 'h55551, 0);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R4", int'(addr_o), 'h55550);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R4", int'(addr_o), 'h55553);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R4", int'(addr_o), 'h55552);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R9", int'(addr_o), 'h55551);
    tick(1, 'h00003, 0);
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R4", int'(addr_o), 'h00002);
    mode_i = 1'b0;
    tick(0, 0, 1);
    tick(0, 0, 0);
    check("R8", int'(addr_o), 'h00001);

    // Mixed strobe patterns in both orders, compared every cycle by the model.
    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      tick(($urandom % 7) == 0, int'($urandom % (1 << ADDR_W)), ($urandom % 3) != 0);
    end
    do_reset(1'b0);
    cur_req = "R3";
    for (int i = 0; i < 300; i++) begin
      tick(($urandom % 7) == 0, int'($urandom % (1 << ADDR_W)), ($urandom % 3) != 0);
    end
    tick(0, 0, 0);
    tick(0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule